// File: doc/BRIEF.md
# Fixed-Latency Bit-Serial Reducer Modulo the Ed25519 Group Order

This block reduces a wide hash value modulo the prime order l of the Ed25519 base point subgroup, where l = 2^252 + 27742317777372353535851937790883648493. A request presents a 512-bit digest together with a one-cycle start. The block then works through the digest one bit at a time, beginning with the most significant bit. For each bit it doubles a running remainder, adds the bit and subtracts l at most once.

Each bit takes two clock cycles. In the first cycle the block registers both the doubled sum and that sum minus l. In the second cycle it keeps whichever of the two lies in [0, l). The run length depends only on the digest width, so the timing and the control sequence reveal nothing about the value being reduced. The remainder never leaves the range [0, l), so the value returned is canonical.

The digest width, the remainder width and the modulus are parameters. Callers that receive the hash as a byte string place byte k in digest[8k+7:8k], so the integer is read in little-endian byte order.

Top module: `wide_modred`

## Requirements
- R1: After reset, busy, done and result are all 0.
- R2: When done is raised, result equals the digest captured at the accepted start, read as an unsigned integer with digest[IN_W-1] as its most significant bit, modulo MODULUS.
- R3: The internal remainder, and result whenever done is high, are always strictly below MODULUS.
- R4: A start sampled high while busy is low is accepted. done then rises exactly 2*IN_W clock edges later (1,024 with default parameters) for every digest value, and busy is high throughout that span.
- R5: done is high for exactly one cycle, and busy is low in that cycle.
- R6: A start raised while busy is high is ignored: the running reduction keeps its digest and its completion cycle.
- R7: While busy is low and no new start is accepted, result keeps its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request pulse; accepted only when busy is low |
| digest | input | IN_W | Value to reduce, bit IN_W-1 most significant |
| busy | output | 1 | A reduction is in progress |
| done | output | 1 | One-cycle pulse marking a valid result |
| result | output | MOD_W | Remainder modulo MODULUS |

## Verification
The bench builds two copies of the block. The first uses the default 512-bit digest and 253-bit modulus, with zero, all-ones, values near multiples of l and random digests, each compared against a 512-bit remainder worked out in the bench. The second copy uses a 10-bit digest and the modulus 101. Its 20-cycle runs let the bench sweep all 1,024 digests, which covers every carry and borrow pattern of the conditional subtraction. On both copies the bench checks the exact completion cycle, requests raised during a run and the holding of the result afterwards.

// File: rtl/wide_modred.sv
module wide_modred #(
  parameter int IN_W = 512,
  parameter int MOD_W = 253,
  parameter logic [MOD_W-1:0] MODULUS =
    253'h1000000000000000000000000000000014def9dea2f79cd65812631a5cf5d3ed
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IN_W-1:0]  digest,
  output logic             busy,
  output logic             done,
  output logic [MOD_W-1:0] result
);
  localparam int CW = $clog2(IN_W + 1);

  logic [IN_W-1:0]  shreg;
  logic [MOD_W-1:0] acc;
  logic [MOD_W-1:0] keep_q;
  logic [MOD_W-1:0] diff_q;
  logic             neg_q;
  logic             phase;
  logic [CW-1:0]    bits_left;
  logic [MOD_W+1:0] sub;

  assign sub    = {1'b0, acc, shreg[IN_W-1]} - {2'b00, MODULUS};
  assign result = acc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg     <= '0;
      acc       <= '0;
      keep_q    <= '0;
      diff_q    <= '0;
      neg_q     <= 1'b0;
      phase     <= 1'b0;
      bits_left <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          shreg     <= digest;
          acc       <= '0;
          phase     <= 1'b0;
          bits_left <= CW'(IN_W);
          busy      <= 1'b1;
        end
      end else if (!phase) begin
        keep_q <= {acc[MOD_W-2:0], shreg[IN_W-1]};
        diff_q <= sub[MOD_W-1:0];
        neg_q  <= |sub[MOD_W+1:MOD_W];
        phase  <= 1'b1;
      end else begin
        acc       <= neg_q ? keep_q : diff_q;
        shreg     <= {shreg[IN_W-2:0], 1'b0};
        phase     <= 1'b0;
        bits_left <= bits_left - 1'b1;
        if (bits_left == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wide_modred_chk.sv
module wide_modred_chk #(
  parameter int IN_W = 512,
  parameter int MOD_W = 253,
  parameter logic [MOD_W-1:0] MODULUS = '1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [MOD_W-1:0] result,
  input logic [MOD_W-1:0] acc
);
  int unsigned span;
  logic        active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      span   <= 0;
      active <= 1'b0;
    end else if (start && !busy) begin
      span   <= 0;
      active <= 1'b1;
    end else if (active && !done) begin
      span <= span + 1;
    end else begin
      active <= 1'b0;
    end
  end

  p_canonical_acc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc < MODULUS);
  p_canonical_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> result < MODULUS);
  p_fixed_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (active && span == 32'(2 * IN_W)));
  p_busy_span_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && span < 32'(2 * IN_W)) |-> busy);
  p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_idle_at_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_ignore_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !(active && span == 32'(2 * IN_W - 1))) |=> busy);
  p_hold_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(result));
endmodule

bind wide_modred wide_modred_chk #(.IN_W(IN_W), .MOD_W(MOD_W), .MODULUS(MODULUS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .done(done), .result(result), .acc(acc)
);

// File: tb/wide_modred_test.sv
module wide_modred_test;
  localparam int PERIOD = 10;
  localparam int WN = 512;
  localparam int WM = 253;
  localparam int SN = 10;
  localparam int SM = 7;
  localparam logic [WM-1:0] L =
    253'h1000000000000000000000000000000014def9dea2f79cd65812631a5cf5d3ed;
  localparam logic [SM-1:0] SL = 7'd101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic w_start = 1'b0, s_start = 1'b0;
  logic [WN-1:0] w_digest = '0;
  logic [SN-1:0] s_digest = '0;
  logic w_busy, w_done, s_busy, s_done;
  logic [WM-1:0] w_result;
  logic [SM-1:0] s_result;
  int checks = 0, fails = 0, cyc = 0;

  always #(PERIOD / 2) clk = ~clk;

  wide_modred uut (.clk(clk), .rst_n(rst_n), .start(w_start), .digest(w_digest),
    .busy(w_busy), .done(w_done), .result(w_result));
  wide_modred #(.IN_W(SN), .MOD_W(SM), .MODULUS(SL)) uut_small (.clk(clk), .rst_n(rst_n),
    .start(s_start), .digest(s_digest), .busy(s_busy), .done(s_done), .result(s_result));

  task automatic check(input bit ok, input string req, input logic [WN-1:0] act, input logic [WN-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_wide(input logic [WN-1:0] d, input bit poke);
    logic [WN-1:0] exp;
    exp = d % {{(WN-WM){1'b0}}, L};
    @(negedge clk); w_digest = d; w_start = 1'b1;
    @(posedge clk); #1 w_start = 1'b0;
    for (int k = 1; k < 2 * WN; k++) begin
      @(posedge clk); #1;
      if (poke && k == 100) begin w_start = 1'b1; w_digest = ~d; end
      if (poke && k == 110) w_start = 1'b0;
    end
    @(negedge clk);
    check(w_busy && !w_done, "R4 busy through run", {w_busy, w_done}, 2'b10);
    @(negedge clk);
    check(w_done && !w_busy, "R4/R5 done at edge 1024", {w_done, w_busy}, 2'b10);
    check(w_result == exp[WM-1:0], poke ? "R6 restart ignored" : "R2 remainder", w_result, exp);
    check(w_result < L, "R3 canonical", w_result, L);
    @(negedge clk);
    check(!w_done, "R5 single pulse", w_done, 0);
  endtask

  task automatic run_small(input logic [SN-1:0] d, input bit poke);
    logic [SN-1:0] exp;
    exp = d % {3'b0, SL};
    @(negedge clk); s_digest = d; s_start = 1'b1;
    @(posedge clk); #1 s_start = 1'b0;
    for (int k = 1; k < 2 * SN; k++) begin
      @(posedge clk); #1;
      if (poke && k == 3) begin s_start = 1'b1; s_digest = ~d; end
      if (poke && k == 8) s_start = 1'b0;
    end
    @(negedge clk);
    check(s_busy && !s_done, "R4 small busy", {s_busy, s_done}, 2'b10);
    @(negedge clk);
    check(s_done && !s_busy, "R4/R5 small done at edge 20", {s_done, s_busy}, 2'b10);
    check(s_result == exp[SM-1:0], poke ? "R6 small restart ignored" : "R2 small remainder", s_result, exp);
    check(s_result < SL, "R3 small canonical", s_result, SL);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 200000) begin
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [WN-1:0] rnd;
    logic [SM-1:0] held;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!w_busy && !w_done && w_result == 0, "R1 reset wide", {w_busy, w_done, w_result}, 0);
    check(!s_busy && !s_done && s_result == 0, "R1 reset small", {s_busy, s_done, s_result}, 0);
    rst_n = 1'b1;

    for (int v = 0; v < (1 << SN); v++) run_small(SN'(v), 1'b0);
    run_small(10'h3ff, 1'b1);
    run_small(10'h0cb, 1'b1);

    held = s_result;
    repeat (7) @(negedge clk);
    check(s_result == held && !s_done && !s_busy, "R7 result held", s_result, held);

    run_wide('0, 1'b0);
    run_wide('1, 1'b0);
    run_wide({{(WN-WM){1'b0}}, L}, 1'b0);
    run_wide({{(WN-WM){1'b0}}, L} - 1, 1'b0);
    run_wide({{(WN-WM){1'b0}}, L} * 512'd12345, 1'b0);
    for (int i = 0; i < 5; i++) begin
      for (int j = 0; j < 16; j++) rnd[j*32 +: 32] = $urandom;
      run_wide(rnd, i == 2);
    end
    repeat (5) @(negedge clk);
    check(!w_done && !w_busy, "R7 wide idle after run", {w_done, w_busy}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule